// File: doc/BRIEF.md
# Pointer-Selected Register Bank

This block holds the general registers of a small 8-bit processor together with the small selector registers that decide which general register plays which role. One 4-bit selector names the register that serves as program counter, a second names the register used as the memory and I/O index, and a third holds the operand register number taken from the low nibble of the last fetched instruction byte. A call is made by writing a new program-counter selector, with no stack involved: the fetch address at once becomes whatever the newly chosen register holds.

Bytes move between memory and the registers only through an 8-bit data holding register. A load from memory goes into the holding register, and a separate command copies it into one half of the operand register. Reading a register half goes the other way. An interrupt input saves both selectors as one byte and forces fixed registers into the two roles. A return command restores the saved selectors. The sequencer around the block issues one command per clock on a small command code.

Top module: `ptr_regbank`

## Requirements
- R1: After a synchronous reset every general register, the three selectors, the data holding register and the save byte are zero, and interrupts are enabled (`ie_o`=1).
- R2: Command 1 (fetch) latches `data_i[7:4]` into `op_o` and `data_i[3:0]` into the operand selector, and adds one to the register named by the program-counter selector, wrapping from 16'hFFFF to 16'h0000.
- R3: Commands 3 and 4 write the data holding register into the low byte (bits 7:0) or the high byte (bits 15:8) of the operand register and leave the other byte unchanged. Commands 5 and 6 copy the low or high byte of the operand register into the data holding register.
- R4: Command 2 loads `data_i` into the data holding register, and no other command changes a register half from `data_i` directly.
- R5: Command 7 copies the operand selector into the program-counter selector and command 8 copies it into the index selector. From the next cycle `fetch_addr_o` and `index_addr_o` show the contents of the newly chosen registers.
- R6: When `irq_i` is high while `ie_o` is 1, the block saves `{index selector, program-counter selector}` in `saved_o` (index in bits 7:4, program counter in bits 3:0), sets the program-counter selector to 1 and the index selector to 2, and clears `ie_o`.
- R7: While `ie_o` is 0, `irq_i` has no effect, and the command of that cycle executes normally.
- R8: Command 9 (return) restores the program-counter selector from `saved_o[3:0]` and the index selector from `saved_o[7:4]`, and sets `ie_o` to 1. Command 12 sets `ie_o` to 1 without touching the selectors.
- R9: Commands 10 and 11 add one to or subtract one from the operand register, wrapping modulo 2^16.
- R10: In a cycle where an interrupt is accepted, the command on `cmd_i` is discarded. Command 0 and codes 13 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 4 | Command code for this cycle |
| data_i | input | 8 | Memory read data or fetched instruction byte |
| irq_i | input | 1 | Interrupt request |
| fetch_addr_o | output | 16 | Contents of the program-counter register |
| index_addr_o | output | 16 | Contents of the index register |
| operand_val_o | output | 16 | Contents of the operand register |
| d_o | output | 8 | Data holding register |
| p_sel_o | output | 4 | Program-counter selector |
| x_sel_o | output | 4 | Index selector |
| n_sel_o | output | 4 | Operand selector |
| op_o | output | 4 | Operation nibble of the last fetched byte |
| ie_o | output | 1 | Interrupt enable |
| saved_o | output | 8 | Saved selectors, index high nibble, program counter low nibble |

## Verification
The bench builds the block with its default parameters: sixteen registers of two 8-bit halves, so the selectors and instruction nibbles are 4 bits. This width makes a full selector range and the 16-bit wrap at 16'hFFFF reachable in a few commands. It also lets the save byte hold both selectors exactly, so an interrupt round trip can be checked bit for bit. A long pseudo-random command run with sporadic interrupts then drives every selector value through the program-counter and index roles.

// File: rtl/ptr_regbank_pkg.sv
package ptr_regbank_pkg;

    localparam int DEF_NREG   = 16;
    localparam int DEF_BYTE_W = 8;
    localparam int IRQ_P_REG  = 1;
    localparam int IRQ_X_REG  = 2;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_FETCH = 4'd1,
        CMD_LOADD = 4'd2,
        CMD_PUTLO = 4'd3,
        CMD_PUTHI = 4'd4,
        CMD_GETLO = 4'd5,
        CMD_GETHI = 4'd6,
        CMD_SETP  = 4'd7,
        CMD_SETX  = 4'd8,
        CMD_RET   = 4'd9,
        CMD_INC   = 4'd10,
        CMD_DEC   = 4'd11,
        CMD_IEON  = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        WK_NONE = 3'd0,
        WK_INC  = 3'd1,
        WK_DEC  = 3'd2,
        WK_LO   = 3'd3,
        WK_HI   = 3'd4
    } wr_kind_e;

    typedef enum logic [1:0] {
        DS_HOLD = 2'd0,
        DS_MEM  = 2'd1,
        DS_LO   = 2'd2,
        DS_HI   = 2'd3
    } d_src_e;

    typedef struct packed {
        wr_kind_e wr_kind;
        logic     wr_on_p;
        d_src_e   d_src;
        logic     latch_ir;
        logic     set_p;
        logic     set_x;
        logic     ret;
        logic     ie_on;
        logic     take_irq;
    } ctl_t;

    function automatic ctl_t decode_cmd(input logic [3:0] raw, input logic irq_take);
        ctl_t k;
        k = '{wr_kind: WK_NONE, wr_on_p: 1'b0, d_src: DS_HOLD, latch_ir: 1'b0,
              set_p: 1'b0, set_x: 1'b0, ret: 1'b0, ie_on: 1'b0, take_irq: 1'b0};
        if (irq_take) begin
            k.take_irq = 1'b1;
        end else begin
            case (raw)
                CMD_FETCH: begin
                    k.latch_ir = 1'b1;
                    k.wr_kind  = WK_INC;
                    k.wr_on_p  = 1'b1;
                end
                CMD_LOADD: k.d_src   = DS_MEM;
                CMD_PUTLO: k.wr_kind = WK_LO;
                CMD_PUTHI: k.wr_kind = WK_HI;
                CMD_GETLO: k.d_src   = DS_LO;
                CMD_GETHI: k.d_src   = DS_HI;
                CMD_SETP:  k.set_p   = 1'b1;
                CMD_SETX:  k.set_x   = 1'b1;
                CMD_RET:   k.ret     = 1'b1;
                CMD_INC:   k.wr_kind = WK_INC;
                CMD_DEC:   k.wr_kind = WK_DEC;
                CMD_IEON:  k.ie_on   = 1'b1;
                default:   ;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/pr_regarray.sv
module pr_regarray
    import ptr_regbank_pkg::*;
#(
    parameter int NREG   = DEF_NREG,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int SEL_W = $clog2(NREG),
    localparam int REG_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          wr_kind,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [SEL_W-1:0]  p_sel,
    input  logic [SEL_W-1:0]  x_sel,
    input  logic [SEL_W-1:0]  n_sel,
    output logic [REG_W-1:0]  p_val,
    output logic [REG_W-1:0]  x_val,
    output logic [REG_W-1:0]  n_val
);

    logic [REG_W-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        logic [REG_W-1:0] q;
        logic             hit;

        assign hit = (wr_sel == SEL_W'(gi));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                case (wr_kind)
                    WK_INC:  q <= q + REG_W'(1);
                    WK_DEC:  q <= q - REG_W'(1);
                    WK_LO:   q[BYTE_W-1:0] <= wr_byte;
                    WK_HI:   q[REG_W-1:BYTE_W] <= wr_byte;
                    default: ;
                endcase
            end
        end

        assign regs[gi] = q;
    end

    assign p_val = regs[p_sel];
    assign x_val = regs[x_sel];
    assign n_val = regs[n_sel];

    // R2
    inc_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == WK_INC) |=> (regs[$past(wr_sel)] == $past(regs[wr_sel]) + REG_W'(1)));

    // R9
    dec_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == WK_DEC) |=> (regs[$past(wr_sel)] == $past(regs[wr_sel]) - REG_W'(1)));

    // R3
    lo_half_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == WK_LO) |=>
            (regs[$past(wr_sel)][BYTE_W-1:0] == $past(wr_byte)) &&
            (regs[$past(wr_sel)][REG_W-1:BYTE_W] == $past(regs[wr_sel][REG_W-1:BYTE_W])));

    // R3
    hi_half_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == WK_HI) |=>
            (regs[$past(wr_sel)][REG_W-1:BYTE_W] == $past(wr_byte)) &&
            (regs[$past(wr_sel)][BYTE_W-1:0] == $past(regs[wr_sel][BYTE_W-1:0])));

endmodule

// File: rtl/pr_selectors.sv
module pr_selectors
    import ptr_regbank_pkg::*;
#(
    parameter int NREG   = DEF_NREG,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int SEL_W = $clog2(NREG),
    localparam int OP_W  = BYTE_W - SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  ctl_t                ctl,
    input  logic [BYTE_W-1:0]   instr,
    output logic [SEL_W-1:0]    p,
    output logic [SEL_W-1:0]    x,
    output logic [SEL_W-1:0]    n,
    output logic [OP_W-1:0]     op,
    output logic                ie,
    output logic [2*SEL_W-1:0]  saved
);

    always_ff @(posedge clk) begin
        if (rst) begin
            p     <= '0;
            x     <= '0;
            n     <= '0;
            op    <= '0;
            ie    <= 1'b1;
            saved <= '0;
        end else if (ctl.take_irq) begin
            saved <= {x, p};
            p     <= SEL_W'(IRQ_P_REG);
            x     <= SEL_W'(IRQ_X_REG);
            ie    <= 1'b0;
        end else begin
            if (ctl.latch_ir) begin
                op <= instr[BYTE_W-1:SEL_W];
                n  <= instr[SEL_W-1:0];
            end
            if (ctl.set_p) p <= n;
            if (ctl.set_x) x <= n;
            if (ctl.ret) begin
                p  <= saved[SEL_W-1:0];
                x  <= saved[2*SEL_W-1:SEL_W];
                ie <= 1'b1;
            end
            if (ctl.ie_on) ie <= 1'b1;
        end
    end

    // R6
    irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.take_irq |=> (p == SEL_W'(IRQ_P_REG)) && (x == SEL_W'(IRQ_X_REG)) && !ie &&
                          (saved == $past({x, p})));

    // R8
    irq_return_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.ret |=> ie && ({x, p} == $past(saved)));

    // R5
    set_p_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.set_p |=> (p == $past(n)));

    // R7
    p_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.take_irq && !ctl.set_p && !ctl.ret) |=> $stable(p));

endmodule

// File: rtl/pr_accum.sv
module pr_accum
    import ptr_regbank_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int REG_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  d_src_e            src,
    input  logic [BYTE_W-1:0] mem_byte,
    input  logic [REG_W-1:0]  reg_val,
    output logic [BYTE_W-1:0] d
);

    logic [BYTE_W-1:0] d_next;

    always_comb begin
        case (src)
            DS_MEM:  d_next = mem_byte;
            DS_LO:   d_next = reg_val[BYTE_W-1:0];
            DS_HI:   d_next = reg_val[REG_W-1:BYTE_W];
            default: d_next = d;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) d <= '0;
        else     d <= d_next;
    end

    // R4
    mem_load_chk: assert property (@(posedge clk) disable iff (rst)
        (src == DS_MEM) |=> (d == $past(mem_byte)));

    // R4
    d_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src == DS_HOLD) |=> $stable(d));

endmodule

// File: rtl/ptr_regbank.sv
module ptr_regbank
    import ptr_regbank_pkg::*;
#(
    parameter int NREG   = DEF_NREG,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int SEL_W = $clog2(NREG),
    localparam int REG_W = 2 * BYTE_W,
    localparam int OP_W  = BYTE_W - SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          cmd_i,
    input  logic [BYTE_W-1:0]   data_i,
    input  logic                irq_i,
    output logic [REG_W-1:0]    fetch_addr_o,
    output logic [REG_W-1:0]    index_addr_o,
    output logic [REG_W-1:0]    operand_val_o,
    output logic [BYTE_W-1:0]   d_o,
    output logic [SEL_W-1:0]    p_sel_o,
    output logic [SEL_W-1:0]    x_sel_o,
    output logic [SEL_W-1:0]    n_sel_o,
    output logic [OP_W-1:0]     op_o,
    output logic                ie_o,
    output logic [2*SEL_W-1:0]  saved_o
);

    ctl_t             ctl;
    logic [SEL_W-1:0] p, x, n;
    logic [SEL_W-1:0] wr_sel;
    logic [REG_W-1:0] p_val, x_val, n_val;
    logic             ie;

    assign ctl    = decode_cmd(cmd_i, irq_i & ie);
    assign wr_sel = ctl.wr_on_p ? p : n;

    pr_selectors #(.NREG(NREG), .BYTE_W(BYTE_W)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .instr (data_i),
        .p     (p),
        .x     (x),
        .n     (n),
        .op    (op_o),
        .ie    (ie),
        .saved (saved_o)
    );

    pr_regarray #(.NREG(NREG), .BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_kind (ctl.wr_kind),
        .wr_sel  (wr_sel),
        .wr_byte (d_o),
        .p_sel   (p),
        .x_sel   (x),
        .n_sel   (n),
        .p_val   (p_val),
        .x_val   (x_val),
        .n_val   (n_val)
    );

    pr_accum #(.BYTE_W(BYTE_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .src      (ctl.d_src),
        .mem_byte (data_i),
        .reg_val  (n_val),
        .d        (d_o)
    );

    assign fetch_addr_o  = p_val;
    assign index_addr_o  = x_val;
    assign operand_val_o = n_val;
    assign p_sel_o       = p;
    assign x_sel_o       = x;
    assign n_sel_o       = n;
    assign ie_o          = ie;

    // R7
    irq_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_i && !ie_o && (cmd_i == 4'd0)) |=> $stable(p_sel_o) && $stable(x_sel_o) && $stable(saved_o));

    // R10
    irq_discards_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_i && ie_o) |=> $stable(d_o) && $stable(n_sel_o) && $stable(op_o));

endmodule

// File: tb/sim_ptr_regbank.sv
module sim_ptr_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  cmd;
    logic [7:0]  data;
    logic        irq;
    logic [15:0] fetch_addr, index_addr, operand_val;
    logic [7:0]  d, saved;
    logic [3:0]  p_sel, x_sel, n_sel, op;
    logic        ie;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] mr [16];
    logic [3:0]  mp, mx, mn, mop;
    logic [7:0]  md, mt;
    logic        mie;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_regbank u0 (
        .clk           (clk),
        .rst           (rst),
        .cmd_i         (cmd),
        .data_i        (data),
        .irq_i         (irq),
        .fetch_addr_o  (fetch_addr),
        .index_addr_o  (index_addr),
        .operand_val_o (operand_val),
        .d_o           (d),
        .p_sel_o       (p_sel),
        .x_sel_o       (x_sel),
        .n_sel_o       (n_sel),
        .op_o          (op),
        .ie_o          (ie),
        .saved_o       (saved)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "fetch_addr",  fetch_addr,  mr[mp]);
        chk(tag, "index_addr",  index_addr,  mr[mx]);
        chk(tag, "operand_val", operand_val, mr[mn]);
        chk(tag, "d",           {8'h0, d},   {8'h0, md});
        chk(tag, "p_sel",       {12'h0, p_sel}, {12'h0, mp});
        chk(tag, "x_sel",       {12'h0, x_sel}, {12'h0, mx});
        chk(tag, "n_sel",       {12'h0, n_sel}, {12'h0, mn});
        chk(tag, "op",          {12'h0, op},    {12'h0, mop});
        chk(tag, "ie",          {15'h0, ie},    {15'h0, mie});
        chk(tag, "saved",       {8'h0, saved},  {8'h0, mt});
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mr[i] = 16'h0;
        mp = 0; mx = 0; mn = 0; mop = 0; md = 0; mt = 0; mie = 1'b1;
    endtask

    task automatic model_apply(input logic [3:0] c, input logic [7:0] dat, input logic rq);
        if (rq && mie) begin
            mt  = {mx, mp};
            mp  = 4'd1;
            mx  = 4'd2;
            mie = 1'b0;
        end else begin
            case (c)
                4'd1:  begin mop = dat[7:4]; mr[mp] = mr[mp] + 16'd1; mn = dat[3:0]; end
                4'd2:  md = dat;
                4'd3:  mr[mn][7:0]  = md;
                4'd4:  mr[mn][15:8] = md;
                4'd5:  md = mr[mn][7:0];
                4'd6:  md = mr[mn][15:8];
                4'd7:  mp = mn;
                4'd8:  mx = mn;
                4'd9:  begin mp = mt[3:0]; mx = mt[7:4]; mie = 1'b1; end
                4'd10: mr[mn] = mr[mn] + 16'd1;
                4'd11: mr[mn] = mr[mn] - 16'd1;
                4'd12: mie = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic step(input logic [3:0] c, input logic [7:0] dat, input logic rq, input string tag);
        cmd  = c;
        data = dat;
        irq  = rq;
        model_apply(c, dat, rq);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        cmd = 4'd0;
        irq = 1'b0;
    endtask

    initial begin
        for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; cmd = 4'd0; data = 8'h0; irq = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        compare("R1");
        step(4'd0, 8'h00, 1'b0, "R1");
        step(4'd13, 8'hEE, 1'b0, "R10");

        // build 16'h1234 in register 3, reached through the index role
        step(4'd1, 8'h53, 1'b0, "R2");
        step(4'd2, 8'h34, 1'b0, "R4");
        step(4'd3, 8'h00, 1'b0, "R3");
        step(4'd2, 8'h12, 1'b0, "R4");
        step(4'd4, 8'h00, 1'b0, "R3");
        step(4'd8, 8'h00, 1'b0, "R5");
        step(4'd5, 8'h00, 1'b0, "R3");
        step(4'd6, 8'h00, 1'b0, "R3");

        // call: redirect program counter to register 5 holding 16'h00FF
        step(4'd1, 8'h05, 1'b0, "R2");
        step(4'd2, 8'hFF, 1'b0, "R4");
        step(4'd3, 8'h00, 1'b0, "R3");
        step(4'd7, 8'h00, 1'b0, "R5");
        step(4'd1, 8'hA7, 1'b0, "R2");

        // wrap of the program counter at 16'hFFFF
        step(4'd2, 8'hFF, 1'b0, "R4");
        step(4'd3, 8'h00, 1'b0, "R3");
        step(4'd4, 8'h00, 1'b0, "R3");
        step(4'd7, 8'h00, 1'b0, "R5");
        step(4'd1, 8'h09, 1'b0, "R2");

        // operand increment and decrement wrap
        step(4'd11, 8'h00, 1'b0, "R9");
        step(4'd10, 8'h00, 1'b0, "R9");
        step(4'd11, 8'h00, 1'b0, "R9");

        // interrupt entry discards the fetch offered in the same cycle
        step(4'd1, 8'hC4, 1'b1, "R6/R10");
        step(4'd7, 8'h00, 1'b1, "R7");
        step(4'd0, 8'h00, 1'b1, "R7");
        step(4'd9, 8'h00, 1'b0, "R8");
        step(4'd0, 8'h00, 1'b1, "R6");
        step(4'd12, 8'h00, 1'b0, "R8");
        step(4'd9, 8'h00, 1'b0, "R8");

        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(4'(lfsr[3:0] % 13), lfsr[11:4], (lfsr[15:13] == 3'd0), "mix");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule